// File: doc/BRIEF.md
# IPv4 Forwarding Header Processor

This block sits inline on a packet stream made of 64-bit data words, each paired with an 8-bit control word. A nonzero control value marks a module-header word, and a zero control value marks a frame body word. For every packet, the block first captures the module header and the first five body words, which together hold the Ethernet header and the base IPv4 header. It then decides where the packet goes. During that decision it holds its ready signal low. It then emits a new destination header word, the buffered words and the rest of the packet.

The decision is based on three checks: whether the destination MAC address belongs to the receiving port, whether the packet is IPv4, and whether the TTL and header checksum are valid. It then performs a parallel longest-prefix-match on the destination address, followed by a next-hop MAC resolution. A packet that passes everything leaves on the chosen MAC port with rewritten Ethernet addresses, its TTL reduced by one and its checksum patched incrementally. Any packet that fails a check goes unchanged to the host-CPU queue paired with its input port. A packet injected by the CPU bypasses all checks and leaves on the MAC port paired with its CPU queue. Both tables are loaded through one write port.

Top module: `ipfwd_hdr_proc`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_wr` is 0 and `in_rdy` is 1.
- R2: Queue indices are encoded as follows: MAC port k is queue 2k and its paired CPU queue is 2k+1. The input module header has control 0xFF, with bits [15:0] holding the body word count (at least 5) and bits [23:16] holding the source queue index. Byte 0 of the frame sits in bits [63:56] of the first body word. Each packet is output in this order: first a word with control 0x04 whose data is a one-hot destination queue mask in bits [7:0] with all other bits zero, then the unchanged 0xFF word, then every body word with control 0.
- R3: Once the sixth word of a packet has been accepted, `in_rdy` is low in the following cycle. It stays low until the buffered words have been emitted.
- R4: A packet from MAC port k whose destination MAC differs from `PORT_MAC_BASE + k` goes unmodified to queue 2k+1.
- R5: A packet with TTL 0 or 1 goes unmodified to its CPU queue. TTL 2 is forwarded, leaving with TTL 1.
- R6: A packet whose IPv4 header does not sum to 0xFFFF in one's-complement arithmetic goes unmodified to its CPU queue.
- R7: Among the valid prefix entries that match, the one whose mask has the most ones wins. On a tie, the lowest index wins. This holds regardless of the order in which entries are stored.
- R8: A packet that matches no prefix, or whose next hop is absent from the MAC table, goes unmodified to its CPU queue.
- R9: A packet with an ethertype other than 0x0800, or with a first IP header byte other than 0x45, goes unmodified to its CPU queue.
- R10: A forwarded packet leaves on queue 2p, where p is the port of the winning prefix. Its destination MAC is replaced by the resolved MAC and its source MAC becomes `PORT_MAC_BASE + p`. Its TTL is decremented and its checksum is left valid. All other bytes are unchanged.
- R11: A prefix entry with next hop 0 resolves its MAC using the packet's destination address.
- R12: A packet from CPU queue 2k+1 leaves unmodified on queue 2k, even if its TTL, MAC or checksum would otherwise cause an exception.
- R13: A table write with `tbl_valid` = 0 removes the entry at that index. Later packets are decided without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Input stream data word |
| in_ctrl | input | 8 | Input stream control word |
| in_wr | input | 1 | Input word valid |
| in_rdy | output | 1 | Block can take an input word |
| out_data | output | 64 | Output stream data word |
| out_ctrl | output | 8 | Output stream control word |
| out_wr | output | 1 | Output word valid |
| tbl_wr | input | 1 | Table write strobe |
| tbl_arp | input | 1 | 1 writes the MAC table, 0 the prefix table |
| tbl_idx | input | $clog2(TBL_DEPTH) | Entry index |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_ip | input | 32 | Prefix, or next-hop address for the MAC table |
| tbl_mask | input | 32 | Prefix mask |
| tbl_nhop | input | 32 | Next-hop address (0 means directly attached) |
| tbl_port | input | $clog2(NPORT) | Output MAC port of the prefix |
| tbl_mac | input | 48 | Resolved next-hop MAC |

## Verification
The bench stores a /32 host route at a higher index than a covering /24 and /16. A design that picked the first hit by index instead of by mask length would send those packets to the wrong port. TTL 1 is tested against TTL 2, and a checksum off by a single bit is tested too, which catches an off-by-one TTL test or a checksum check that ignores the low bits. Three further cases are covered: a packet injected by the CPU with TTL 0, a directly attached route resolved through the destination address, and route removal through the write port. A design missing any of these would alter the destination mask or the rewritten bytes, and every output word is compared against an independently computed frame.

// File: rtl/ipfwd_pkg.sv
`timescale 1ns/1ps
package ipfwd_pkg;
  localparam logic [7:0]  CTRL_MODHDR   = 8'hFF;
  localparam logic [7:0]  CTRL_DEST     = 8'h04;
  localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
  localparam logic [7:0]  VER_IHL_BASIC = 8'h45;
  localparam int          CAP_WORDS     = 6;

  typedef enum logic [2:0] {
    ST_CAPT, ST_LPM, ST_ARP, ST_DEST, ST_BUF, ST_PASS
  } fwd_state_e;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction
endpackage

// File: rtl/ipfwd_lpm.sv
`timescale 1ns/1ps
module ipfwd_lpm #(
  parameter int DEPTH = 8,
  parameter int PORTW = 2,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_valid,
  input  logic [31:0]      wr_pfx,
  input  logic [31:0]      wr_msk,
  input  logic [31:0]      wr_nhop,
  input  logic [PORTW-1:0] wr_port,
  input  logic [31:0]      key,
  output logic             lk_hit,
  output logic [31:0]      lk_nhop,
  output logic [PORTW-1:0] lk_port
);
  logic [DEPTH-1:0] ent_v;
  logic [31:0]      ent_pfx  [DEPTH];
  logic [31:0]      ent_msk  [DEPTH];
  logic [31:0]      ent_nh   [DEPTH];
  logic [PORTW-1:0] ent_port [DEPTH];
  logic [DEPTH-1:0] match;
  logic [5:0]       mlen [DEPTH];
  logic [IW-1:0]    sel;
  logic [5:0]       best;

  always_ff @(posedge clk) begin
    if (rst) ent_v <= '0;
    else if (wr_en) ent_v[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_pfx[wr_idx]  <= wr_pfx & wr_msk;
      ent_msk[wr_idx]  <= wr_msk;
      ent_nh[wr_idx]   <= wr_nhop;
      ent_port[wr_idx] <= wr_port;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_v[g] && ((key & ent_msk[g]) == ent_pfx[g]);
    assign mlen[g]  = 6'($countones(ent_msk[g]));
  end

  // Longest mask wins; strict compare keeps the lowest index on a tie.
  always_comb begin
    lk_hit = 1'b0;
    best   = '0;
    sel    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!lk_hit || mlen[i] > best)) begin
        lk_hit = 1'b1;
        best   = mlen[i];
        sel    = IW'(i);
      end
    end
  end

  assign lk_nhop = ent_nh[sel];
  assign lk_port = ent_port[sel];
endmodule

// File: rtl/ipfwd_arp.sv
`timescale 1ns/1ps
module ipfwd_arp #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [31:0]   wr_ip,
  input  logic [47:0]   wr_mac,
  input  logic [31:0]   key,
  output logic          lk_hit,
  output logic [47:0]   lk_mac
);
  logic [DEPTH-1:0] ent_v;
  logic [31:0]      ent_ip  [DEPTH];
  logic [47:0]      ent_mac [DEPTH];
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) ent_v <= '0;
    else if (wr_en) ent_v[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_ip[wr_idx]  <= wr_ip;
      ent_mac[wr_idx] <= wr_mac;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_ip[g] == key);
  end

  always_comb begin
    lk_hit = |match;
    lk_mac = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match[i]) lk_mac = ent_mac[i];
  end
endmodule

// File: rtl/ipfwd_hdr_proc.sv
`timescale 1ns/1ps
module ipfwd_hdr_proc
  import ipfwd_pkg::*;
#(
  parameter int          NPORT         = 4,
  parameter int          TBL_DEPTH     = 8,
  parameter logic [47:0] PORT_MAC_BASE = 48'h02_00_00_00_00_00,
  localparam int NQ    = 2 * NPORT,
  localparam int QW    = $clog2(NQ),
  localparam int PORTW = $clog2(NPORT),
  localparam int IW    = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [63:0]      in_data,
  input  logic [7:0]       in_ctrl,
  input  logic             in_wr,
  output logic             in_rdy,
  output logic [63:0]      out_data,
  output logic [7:0]       out_ctrl,
  output logic             out_wr,
  input  logic             tbl_wr,
  input  logic             tbl_arp,
  input  logic [IW-1:0]    tbl_idx,
  input  logic             tbl_valid,
  input  logic [31:0]      tbl_ip,
  input  logic [31:0]      tbl_mask,
  input  logic [31:0]      tbl_nhop,
  input  logic [PORTW-1:0] tbl_port,
  input  logic [47:0]      tbl_mac
);
  fwd_state_e       state;
  logic [2:0]       cnt;
  logic [15:0]      rem;
  logic [63:0]      hbuf [CAP_WORDS];
  logic             exc_q, fwd_q;
  logic [31:0]      nh_q;
  logic [PORTW-1:0] oport_q;
  logic [NQ-1:0]    dest_q;
  logic [47:0]      nmac_q;

  logic [QW-1:0]    src_q;
  logic [47:0]      in_mac, out_mac, dst_mac, arp_mac;
  logic [7:0]       ttl, proto;
  logic [15:0]      hsum, csum, new_csum;
  logic [31:0]      dst_ip, lpm_nhop, arp_key;
  logic             lpm_hit, arp_hit, base_exc, acc;
  logic [PORTW-1:0] lpm_port;
  logic [63:0]      emit_word;

  assign in_rdy  = (state == ST_CAPT) || (state == ST_PASS);
  assign acc     = in_wr && in_rdy;
  assign src_q   = hbuf[0][16 +: QW];
  assign in_mac  = PORT_MAC_BASE + 48'(src_q[QW-1:1]);
  assign out_mac = PORT_MAC_BASE + 48'(oport_q);
  assign dst_mac = hbuf[1][63:16];
  assign ttl     = hbuf[3][15:8];
  assign proto   = hbuf[3][7:0];
  assign csum    = hbuf[4][63:48];
  assign dst_ip  = {hbuf[4][15:0], hbuf[5][63:48]};
  assign arp_key = (nh_q == 32'd0) ? dst_ip : nh_q;

  // One's-complement sum over the 20-byte base IPv4 header.
  always_comb begin
    hsum = hbuf[2][15:0];
    for (int h = 0; h < 4; h++) begin
      hsum = oc_add(hsum, hbuf[3][h*16 +: 16]);
      hsum = oc_add(hsum, hbuf[4][h*16 +: 16]);
    end
    hsum = oc_add(hsum, hbuf[5][63:48]);
  end

  assign base_exc = (dst_mac != in_mac) || (hbuf[2][31:16] != ETYPE_IPV4) ||
                    (hbuf[2][15:8] != VER_IHL_BASIC) || (ttl <= 8'd1) ||
                    (hsum != 16'hFFFF);

  // Incremental update: HC' = ~(~HC + ~m + m') with m the TTL/protocol word.
  assign new_csum = ~oc_add(oc_add(~csum, ~{ttl, proto}), {ttl - 8'd1, proto});

  ipfwd_lpm #(.DEPTH(TBL_DEPTH), .PORTW(PORTW)) u_lpm (
    .clk, .rst, .wr_en(tbl_wr && !tbl_arp), .wr_idx(tbl_idx), .wr_valid(tbl_valid),
    .wr_pfx(tbl_ip), .wr_msk(tbl_mask), .wr_nhop(tbl_nhop), .wr_port(tbl_port),
    .key(dst_ip), .lk_hit(lpm_hit), .lk_nhop(lpm_nhop), .lk_port(lpm_port)
  );

  ipfwd_arp #(.DEPTH(TBL_DEPTH)) u_arp (
    .clk, .rst, .wr_en(tbl_wr && tbl_arp), .wr_idx(tbl_idx), .wr_valid(tbl_valid),
    .wr_ip(tbl_ip), .wr_mac(tbl_mac), .key(arp_key), .lk_hit(arp_hit), .lk_mac(arp_mac)
  );

  always_comb begin
    emit_word = hbuf[cnt];
    if (fwd_q) begin
      case (cnt)
        3'd1: emit_word = {nmac_q, out_mac[47:32]};
        3'd2: emit_word = {out_mac[31:0], hbuf[2][31:0]};
        3'd3: emit_word = {hbuf[3][63:16], ttl - 8'd1, proto};
        3'd4: emit_word = {new_csum, hbuf[4][47:0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_CAPT && acc) hbuf[cnt] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_CAPT;
      cnt    <= '0;
      rem    <= '0;
      out_wr <= 1'b0;
      fwd_q  <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      out_wr <= 1'b0;
      case (state)
        ST_CAPT: if (acc) begin
          if (cnt == 3'(CAP_WORDS - 1)) begin
            cnt   <= '0;
            state <= ST_LPM;
          end else cnt <= cnt + 3'd1;
        end
        ST_LPM: begin
          exc_q   <= base_exc || !lpm_hit;
          nh_q    <= lpm_nhop;
          oport_q <= lpm_port;
          state   <= ST_ARP;
        end
        ST_ARP: begin
          nmac_q <= arp_mac;
          state  <= ST_DEST;
          if (src_q[0]) begin
            dest_q <= NQ'(1) << {src_q[QW-1:1], 1'b0};
            fwd_q  <= 1'b0;
          end else if (exc_q || !arp_hit) begin
            dest_q <= NQ'(1) << {src_q[QW-1:1], 1'b1};
            fwd_q  <= 1'b0;
          end else begin
            dest_q <= NQ'(1) << {oport_q, 1'b0};
            fwd_q  <= 1'b1;
          end
        end
        ST_DEST: begin
          out_wr   <= 1'b1;
          out_ctrl <= CTRL_DEST;
          out_data <= 64'(dest_q);
          cnt      <= '0;
          state    <= ST_BUF;
        end
        ST_BUF: begin
          out_wr   <= 1'b1;
          out_ctrl <= (cnt == 3'd0) ? CTRL_MODHDR : 8'h00;
          out_data <= emit_word;
          if (cnt == 3'(CAP_WORDS - 1)) begin
            cnt   <= '0;
            rem   <= hbuf[0][15:0] - 16'(CAP_WORDS - 1);
            state <= (hbuf[0][15:0] > 16'(CAP_WORDS - 1)) ? ST_PASS : ST_CAPT;
          end else cnt <= cnt + 3'd1;
        end
        ST_PASS: if (acc) begin
          out_wr   <= 1'b1;
          out_ctrl <= in_ctrl;
          out_data <= in_data;
          rem      <= rem - 16'd1;
          if (rem == 16'd1) state <= ST_CAPT;
        end
        default: state <= ST_CAPT;
      endcase
    end
  end

  AST_DEST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (out_wr && out_ctrl == CTRL_DEST) |-> $onehot(out_data[NQ-1:0])); // R2
  AST_DEST_BEFORE_HDR: assert property (@(posedge clk) disable iff (rst)
    (out_wr && out_ctrl == CTRL_DEST) |=> (out_wr && out_ctrl == CTRL_MODHDR)); // R2
  AST_STALL_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && acc && cnt == 3'(CAP_WORDS - 1)) |=> !in_rdy); // R3
  AST_FWD_TTL_ABOVE_ONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEST && fwd_q) |-> (ttl > 8'd1)); // R5
  AST_CPU_NOT_REWRITTEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEST && src_q[0]) |-> !fwd_q); // R12
endmodule

// File: tb/tb_ipfwd_hdr_proc.sv
`timescale 1ns/1ps
module tb_ipfwd_hdr_proc;
  localparam int NPORT = 4;
  localparam int NQ    = 8;
  localparam int PORTW = 2;
  localparam int DEPTH = 8;
  localparam int IW    = 3;
  localparam logic [47:0] MBASE = 48'h02_00_00_00_00_00;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [63:0] in_data, out_data;
  logic [7:0]  in_ctrl, out_ctrl;
  logic in_wr, in_rdy, out_wr;
  logic tbl_wr, tbl_arp, tbl_valid;
  logic [IW-1:0] tbl_idx;
  logic [31:0] tbl_ip, tbl_mask, tbl_nhop;
  logic [PORTW-1:0] tbl_port;
  logic [47:0] tbl_mac;

  ipfwd_hdr_proc #(.NPORT(NPORT), .TBL_DEPTH(DEPTH), .PORT_MAC_BASE(MBASE)) dut (
    .clk, .rst, .in_data, .in_ctrl, .in_wr, .in_rdy, .out_data, .out_ctrl, .out_wr,
    .tbl_wr, .tbl_arp, .tbl_idx, .tbl_valid, .tbl_ip, .tbl_mask, .tbl_nhop,
    .tbl_port, .tbl_mac
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] eq_d[$];
  logic [7:0]  eq_c[$];
  string       eq_t[$];
  logic [7:0]  pb [0:127];

  bit          m_lv [DEPTH];
  logic [31:0] m_lp [DEPTH], m_lm [DEPTH], m_ln [DEPTH];
  int          m_lo [DEPTH];
  bit          m_av [DEPTH];
  logic [31:0] m_ai [DEPTH];
  logic [47:0] m_am [DEPTH];

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_hdr();
    int s = 0;
    for (int i = 14; i < 34; i += 2) s += int'({pb[i], pb[i+1]});
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return 16'(s);
  endfunction

  task automatic put(int off, int n, logic [63:0] v);
    for (int i = 0; i < n; i++) pb[off+i] = v[8*(n-1-i) +: 8];
  endtask

  function automatic logic [63:0] get(int off, int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(pb[off+i]);
    return v;
  endfunction

  task automatic make_pkt(logic [47:0] dmac, logic [15:0] et, logic [7:0] ttl,
                          logic [31:0] dip, int nbody, bit badcs);
    for (int i = 0; i < nbody*8; i++) pb[i] = 8'(i*7 + 3);
    put(0, 6, 64'(dmac)); put(6, 6, 64'h0A0B0C0D0E0F); put(12, 2, 64'(et));
    pb[14] = 8'h45; pb[15] = 8'h00; put(16, 2, 64'(nbody*8 - 14));
    put(18, 2, 64'h1234); put(20, 2, 64'h0); pb[22] = ttl; pb[23] = 8'h06;
    put(24, 2, 64'h0); put(26, 4, 64'hC0A80001); put(30, 4, 64'(dip));
    put(24, 2, 64'(~sum_hdr() ^ (badcs ? 16'h0001 : 16'h0000)));
  endtask

  task automatic send_pkt(int src, int nbody, string tag);
    logic [63:0] orig [0:15];
    logic [63:0] hdr;
    logic [NQ-1:0] dst;
    logic [31:0] dip, key;
    bit exc;
    int best = -1;
    int blen = 0;
    int ahit = -1;
    for (int w = 0; w < nbody; w++) orig[w] = get(w*8, 8);
    hdr = {40'b0, 8'(src), 16'(nbody)};
    dip = 32'(get(30, 4));
    if ((src % 2) == 1) dst = NQ'(1) << (src - 1);
    else begin
      exc = (48'(get(0, 6)) != MBASE + 48'(src/2)) || (16'(get(12, 2)) != 16'h0800) ||
            (pb[14] != 8'h45) || (pb[22] < 8'd2) || (sum_hdr() != 16'hFFFF);
      for (int i = 0; i < DEPTH; i++)
        if (m_lv[i] && ((dip & m_lm[i]) == (m_lp[i] & m_lm[i])) &&
            (best < 0 || $countones(m_lm[i]) > blen)) begin
          best = i;
          blen = $countones(m_lm[i]);
        end
      if (best < 0) exc = 1;
      else begin
        key = (m_ln[best] == 32'd0) ? dip : m_ln[best];
        for (int i = DEPTH - 1; i >= 0; i--)
          if (m_av[i] && m_ai[i] == key) ahit = i;
        if (ahit < 0) exc = 1;
      end
      if (exc) dst = NQ'(1) << (src + 1);
      else begin
        dst = NQ'(1) << (2 * m_lo[best]);
        put(0, 6, 64'(m_am[ahit]));
        put(6, 6, 64'(MBASE + 48'(m_lo[best])));
        pb[22] = pb[22] - 8'd1;
        put(24, 2, 64'h0);
        put(24, 2, 64'(~sum_hdr()));
      end
    end
    eq_d.push_back(64'(dst)); eq_c.push_back(8'h04); eq_t.push_back({"R2 dest word ", tag});
    eq_d.push_back(hdr);      eq_c.push_back(8'hFF); eq_t.push_back({"R2 module header ", tag});
    for (int w = 0; w < nbody; w++) begin
      eq_d.push_back(get(w*8, 8)); eq_c.push_back(8'h00); eq_t.push_back({"body ", tag});
    end
    for (int w = 0; w <= nbody; w++) begin
      @(negedge clk);
      in_wr = 1'b0;
      if (w == 6) check(!in_rdy, {"R3 stall ", tag}, 64'(in_rdy), 64'd0);
      while (!in_rdy) @(negedge clk);
      in_wr   = 1'b1;
      in_ctrl = (w == 0) ? 8'hFF : 8'h00;
      in_data = (w == 0) ? hdr : orig[w-1];
    end
    @(negedge clk);
    in_wr = 1'b0;
    if (nbody == 5) check(!in_rdy, {"R3 stall ", tag}, 64'(in_rdy), 64'd0);
  endtask

  task automatic lpm_wr(int i, bit v, logic [31:0] p, logic [31:0] m, logic [31:0] nh, int port);
    m_lv[i] = v; m_lp[i] = p; m_lm[i] = m; m_ln[i] = nh; m_lo[i] = port;
    @(negedge clk);
    tbl_wr = 1'b1; tbl_arp = 1'b0; tbl_idx = IW'(i); tbl_valid = v;
    tbl_ip = p; tbl_mask = m; tbl_nhop = nh; tbl_port = PORTW'(port);
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic arp_wr(int i, bit v, logic [31:0] ip, logic [47:0] mac);
    m_av[i] = v; m_ai[i] = ip; m_am[i] = mac;
    @(negedge clk);
    tbl_wr = 1'b1; tbl_arp = 1'b1; tbl_idx = IW'(i); tbl_valid = v;
    tbl_ip = ip; tbl_mac = mac;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (eq_d.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin : monitor
    logic [63:0] d;
    logic [7:0] c;
    string t;
    if (!rst && out_wr) begin
      if (eq_d.size() == 0) check(1'b0, "R2 unexpected output word", out_data, 64'd0);
      else begin
        d = eq_d.pop_front(); c = eq_c.pop_front(); t = eq_t.pop_front();
        check(out_data == d, t, out_data, d);
        check(out_ctrl == c, {"R2 ctrl ", t}, 64'(out_ctrl), 64'(c));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_lv[i] = 0; m_av[i] = 0; end
    rst = 1'b1; in_wr = 1'b0; in_data = '0; in_ctrl = '0;
    tbl_wr = 1'b0; tbl_arp = 1'b0; tbl_idx = '0; tbl_valid = 1'b0;
    tbl_ip = '0; tbl_mask = '0; tbl_nhop = '0; tbl_port = '0; tbl_mac = '0;
    repeat (4) @(negedge clk);
    check(out_wr == 1'b0, "R1 out_wr in reset", 64'(out_wr), 64'd0);
    check(in_rdy == 1'b1, "R1 in_rdy in reset", 64'(in_rdy), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    check(out_wr == 1'b0, "R1 out_wr after reset", 64'(out_wr), 64'd0);
    check(in_rdy == 1'b1, "R1 in_rdy after reset", 64'(in_rdy), 64'd1);

    lpm_wr(0, 1, 32'h0A000000, 32'hFF000000, 32'h0A010101, 1);
    lpm_wr(1, 1, 32'h0A020000, 32'hFFFF0000, 32'h00000000, 2);
    lpm_wr(2, 1, 32'h0A020300, 32'hFFFFFF00, 32'h0A090909, 3);
    lpm_wr(5, 1, 32'h0A020304, 32'hFFFFFFFF, 32'h0A010101, 0);
    arp_wr(0, 1, 32'h0A010101, 48'h00AA00000001);
    arp_wr(3, 1, 32'h0A020707, 48'h00BB00000002);
    arp_wr(6, 1, 32'h0A090909, 48'h00CC00000003);

    make_pkt(MBASE + 0, 16'h0800, 8'd64, 32'h0A050505, 5, 0); send_pkt(0, 5, "R10 /8 route");
    make_pkt(MBASE + 0, 16'h0800, 8'd64, 32'h0A020707, 7, 0); send_pkt(0, 7, "R11 R7 direct /16");
    make_pkt(MBASE + 0, 16'h0800, 8'd30, 32'h0A020399, 6, 0); send_pkt(0, 6, "R7 /24 route");
    make_pkt(MBASE + 0, 16'h0800, 8'd9,  32'h0A020304, 5, 0); send_pkt(0, 5, "R7 host route at higher index");
    make_pkt(MBASE + 0, 16'h0800, 8'd64, 32'h0A020808, 5, 0); send_pkt(0, 5, "R8 next hop MAC miss");
    make_pkt(MBASE + 0, 16'h0800, 8'd64, 32'hC0A80101, 5, 0); send_pkt(0, 5, "R8 prefix miss");
    make_pkt(MBASE + 0, 16'h0800, 8'd1,  32'h0A050505, 5, 0); send_pkt(0, 5, "R5 TTL 1");
    make_pkt(MBASE + 0, 16'h0800, 8'd0,  32'h0A050505, 5, 0); send_pkt(0, 5, "R5 TTL 0");
    make_pkt(MBASE + 0, 16'h0800, 8'd64, 32'h0A050505, 5, 1); send_pkt(0, 5, "R6 bad checksum");
    make_pkt(MBASE + 0, 16'h0800, 8'd64, 32'h0A050505, 5, 0); send_pkt(2, 5, "R4 MAC of other port");
    make_pkt(MBASE + 1, 16'h0800, 8'd2,  32'h0A050505, 6, 0); send_pkt(2, 6, "R4 R5 R10 TTL 2 forwarded");
    make_pkt(MBASE + 3, 16'h0800, 8'd0,  32'hC0A80101, 5, 1); send_pkt(3, 5, "R12 CPU injected");
    make_pkt(MBASE + 0, 16'h0806, 8'd64, 32'h0A050505, 5, 0); send_pkt(0, 5, "R9 non-IPv4 ethertype");
    make_pkt(MBASE + 2, 16'h0800, 8'd77, 32'h0A020399, 12, 0); send_pkt(4, 12, "R10 R2 long packet");
    wait_idle();

    lpm_wr(5, 0, 32'h0A020304, 32'hFFFFFFFF, 32'h0A010101, 0);
    make_pkt(MBASE + 0, 16'h0800, 8'd9, 32'h0A020304, 5, 0); send_pkt(0, 5, "R13 host route removed");
    wait_idle();
    arp_wr(6, 0, 32'h0A090909, 48'h00CC00000003);
    make_pkt(MBASE + 0, 16'h0800, 8'd9, 32'h0A020399, 5, 0); send_pkt(0, 5, "R13 R8 MAC entry removed");
    wait_idle();

    check(eq_d.size() == 0, "R2 words never emitted", 64'(eq_d.size()), 64'd0);
    finish_run();
  end
endmodule